// File: doc/BRIEF.md
# Selectable Reference Divider Chain

This block takes a crystal-rate reference clock and divides it down to the phase-comparison rate of a frequency synthesizer. A one-bit select input chooses the overall ratio. When the select is 1 the ratio is 1024, and when it is 0 the ratio is 2048. With a 10.24 MHz reference, these give 10 kHz and 5 kHz. The first stage is a fixed divide-by-two, and its output is also brought out as a half-rate clock (5.12 MHz from 10.24 MHz). That stage counts toward the overall ratio, so the stage behind it divides by 512 or 1024.

The comparison rate leaves the block as a strobe that is one reference cycle wide, for use by a phase detector running on the same clock. The select input is sampled once per output period, so moving it in the middle of a period can never produce a short period.

Top module: `ref_ratio_divider`

## Requirements
- R1: While `rst_n` is low, `half_clk` and `cmp_strobe` are both 0. Counting starts again from the beginning when reset is released.
- R2: `half_clk` changes value on every reference rising edge, which gives a 50 percent duty cycle. It is 1 after the odd-numbered edges that follow reset release and 0 after the even-numbered ones.
- R3: `cmp_strobe` is never high for two reference cycles in a row.
- R4: A period whose ratio was sampled as `ratio_sel` = 1 lasts exactly 1024 reference cycles, from strobe to strobe.
- R5: A period whose ratio was sampled as `ratio_sel` = 0 lasts exactly 2048 reference cycles.
- R6: The ratio is sampled only at two points: on the first rising edge after reset release, and on the rising edge that ends the cycle in which `cmp_strobe` is high. A change of `ratio_sel` at any other time does not alter the period in progress.
- R7: `cmp_strobe` rises on the same edge on which `half_clk` falls, so it is only ever high while `half_clk` is 0.
- R8: After reset release, the first strobe appears after edge N, where N is the ratio sampled on the first edge (1024 or 2048). No strobe appears before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Crystal-rate reference clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ratio_sel | input | 1 | 1: divide by 1024, 0: divide by 2048 |
| half_clk | output | 1 | Divide-by-two output, 50 percent duty |
| cmp_strobe | output | 1 | One-cycle comparison strobe at the selected rate |

## Verification
The hardest case to reach is a select change that lands in the middle of a period. Only the value present in the single strobe cycle is allowed to count. The stimulus moves `ratio_sel` at random points inside periods, and it picks a fresh random value in every strobe cycle. The bench then checks that each strobe falls exactly 1024 or 2048 edges after the previous one, according to the value that was present in that strobe cycle. A reset applied in the middle of a period checks that the first period after release is counted from the beginning again.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  typedef enum logic {
    RATIO_LONG  = 1'b0,
    RATIO_SHORT = 1'b1
  } ratio_e;

  function automatic int unsigned stage_limit(input int unsigned total);
    return total / 2;
  endfunction

endpackage

// File: rtl/refdiv_half_stage.sv
module refdiv_half_stage (
  input  logic clk_ref,
  input  logic rst_n,
  output logic half_o
);
  logic half_q, half_d;

  always_comb begin
    half_d = ~half_q;
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= half_d;
  end

  assign half_o = half_q;
endmodule

// File: rtl/refdiv_ratio_hold.sv
module refdiv_ratio_hold
  import refdiv_pkg::*;
(
  input  logic   clk_ref,
  input  logic   rst_n,
  input  logic   sel_i,
  input  logic   load_i,
  output ratio_e ratio_o
);
  ratio_e ratio_q, ratio_d;

  always_comb begin
    ratio_d = ratio_q;
    if (load_i) ratio_d = ratio_e'(sel_i);
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) ratio_q <= RATIO_LONG;
    else        ratio_q <= ratio_d;
  end

  assign ratio_o = ratio_q;
endmodule

// File: rtl/refdiv_count_stage.sv
module refdiv_count_stage
  import refdiv_pkg::*;
#(
  parameter int unsigned LONG_STEPS  = 1024,
  parameter int unsigned SHORT_STEPS = 512
) (
  input  logic   clk_ref,
  input  logic   rst_n,
  input  logic   en_i,
  input  ratio_e ratio_i,
  output logic   idle_o,
  output logic   strobe_o
);
  localparam int unsigned CW = (LONG_STEPS > 2) ? $clog2(LONG_STEPS) : 1;
  localparam logic [CW-1:0] LONG_TC  = CW'(LONG_STEPS - 1);
  localparam logic [CW-1:0] SHORT_TC = CW'(SHORT_STEPS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          strobe_q, strobe_d;
  logic [CW-1:0] tc;
  logic          at_tc;

  always_comb begin
    tc       = (ratio_i == RATIO_SHORT) ? SHORT_TC : LONG_TC;
    at_tc    = (cnt_q == tc);
    cnt_d    = cnt_q;
    strobe_d = 1'b0;
    if (en_i) begin
      if (at_tc) begin
        cnt_d    = '0;
        strobe_d = 1'b1;
      end else begin
        cnt_d    = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      strobe_q <= strobe_d;
    end
  end

  assign idle_o   = (cnt_q == '0);
  assign strobe_o = strobe_q;
endmodule

// File: rtl/ref_ratio_divider.sv
module ref_ratio_divider
  import refdiv_pkg::*;
#(
  parameter int unsigned TOTAL_LONG  = 2048,
  parameter int unsigned TOTAL_SHORT = 1024
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic ratio_sel,
  output logic half_clk,
  output logic cmp_strobe
);
  localparam int unsigned LONG_STEPS  = stage_limit(TOTAL_LONG);
  localparam int unsigned SHORT_STEPS = stage_limit(TOTAL_SHORT);

  logic   half_w;
  logic   idle_w;
  logic   load_w;
  ratio_e ratio_w;

  refdiv_half_stage u_half (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .half_o  (half_w)
  );

  // Ratio is taken in the first cycle of each period: counter at zero, prescaler low.
  assign load_w = idle_w & ~half_w;

  refdiv_ratio_hold u_hold (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .sel_i   (ratio_sel),
    .load_i  (load_w),
    .ratio_o (ratio_w)
  );

  refdiv_count_stage #(
    .LONG_STEPS  (LONG_STEPS),
    .SHORT_STEPS (SHORT_STEPS)
  ) u_cnt (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .en_i     (half_w),
    .ratio_i  (ratio_w),
    .idle_o   (idle_w),
    .strobe_o (cmp_strobe)
  );

  assign half_clk = half_w;
endmodule

// File: rtl/refdiv_checker.sv
module refdiv_checker #(
  parameter int unsigned TOTAL_LONG  = 2048,
  parameter int unsigned TOTAL_SHORT = 1024
) (
  input logic clk_ref,
  input logic rst_n,
  input logic ratio_sel,
  input logic half_clk,
  input logic cmp_strobe
);
  localparam int unsigned GW = $clog2(TOTAL_LONG) + 2;
  localparam logic [GW-1:0] N_LONG  = GW'(TOTAL_LONG);
  localparam logic [GW-1:0] N_SHORT = GW'(TOTAL_SHORT);

  logic [GW-1:0] gap_q, want_q;
  logic          first_q;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= '0;
      want_q  <= N_LONG;
      first_q <= 1'b1;
    end else begin
      first_q <= 1'b0;
      gap_q   <= cmp_strobe ? GW'(1) : gap_q + 1'b1;
      if (cmp_strobe || first_q) want_q <= ratio_sel ? N_SHORT : N_LONG;
    end
  end

  AST_HALF_TOGGLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    1'b1 |=> (half_clk != $past(half_clk))); // R2
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    cmp_strobe |=> !cmp_strobe); // R3
  AST_PERIOD_EXACT: assert property (@(posedge clk_ref) disable iff (!rst_n)
    cmp_strobe |-> (gap_q == want_q)); // R6
  AST_NO_EARLY_STROBE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !cmp_strobe |-> (gap_q <= want_q)); // R8
  AST_STROBE_ALIGN: assert property (@(posedge clk_ref) disable iff (!rst_n)
    cmp_strobe |-> !half_clk); // R7
endmodule

bind ref_ratio_divider refdiv_checker #(
  .TOTAL_LONG  (TOTAL_LONG),
  .TOTAL_SHORT (TOTAL_SHORT)
) u_chk (
  .clk_ref    (clk_ref),
  .rst_n      (rst_n),
  .ratio_sel  (ratio_sel),
  .half_clk   (half_clk),
  .cmp_strobe (cmp_strobe)
);

// File: tb/sim_ref_ratio_divider.sv
module sim_ref_ratio_divider;
  logic clk_ref = 1'b0;
  logic rst_n   = 1'b0;
  logic ratio_sel = 1'b1;
  logic half_clk, cmp_strobe;

  int n_cmp  = 0;
  int n_bad  = 0;
  int k      = 0;
  int exp_k  = 0;
  int cur_n  = 0;
  bit done   = 1'b0;
  bit first_period = 1'b1;

  always #2 clk_ref = ~clk_ref;

  ref_ratio_divider u0 (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .ratio_sel  (ratio_sel),
    .half_clk   (half_clk),
    .cmp_strobe (cmp_strobe)
  );

  function automatic int ratio_of(input logic s);
    return s ? 1024 : 2048;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, k);
    end
  endtask

  // Release at a falling edge; the ratio on ratio_sel is taken by edge 1 (R6, R8).
  task automatic release_reset(input logic s);
    @(negedge clk_ref);
    ratio_sel = s;
    rst_n = 1'b1;
    k = 0;
    cur_n = ratio_of(s);
    exp_k = cur_n;
    first_period = 1'b1;
  endtask

  // force_sel: -1 random with mid-period flips, otherwise a fixed value.
  task automatic run_cycles(input int n, input int force_sel, input int flip_per_mille);
    for (int i = 0; i < n; i++) begin
      bit strb;
      @(posedge clk_ref);
      #1;
      k++;
      check(half_clk == k[0], "R2 half_clk level", int'(half_clk), int'(k[0]));
      strb = cmp_strobe;
      if (strb || k == exp_k) begin
        if (first_period)
          check(strb && k == exp_k, "R8 first strobe edge", k, exp_k);
        else if (cur_n == 1024)
          check(strb && k == exp_k, "R4 period 1024 / R6", k, exp_k);
        else
          check(strb && k == exp_k, "R5 period 2048 / R6", k, exp_k);
        if (strb) check(half_clk == 1'b0, "R7 strobe with half low", int'(half_clk), 0);
      end
      @(negedge clk_ref);
      if (strb) begin
        check(cmp_strobe == 1'b1, "R3 strobe held to cycle end", int'(cmp_strobe), 1);
        ratio_sel = (force_sel < 0) ? logic'($urandom % 2) : logic'(force_sel);
        cur_n = ratio_of(ratio_sel);
        exp_k = k + cur_n;
        first_period = 1'b0;
      end else if (force_sel < 0 && ($urandom % 1000) < flip_per_mille) begin
        ratio_sel = logic'($urandom % 2);
      end
    end
    @(posedge clk_ref);
    #1;
    k++;
    if (cmp_strobe && k != exp_k) check(1'b0, "R3 extra strobe", k, exp_k);
    check(half_clk == k[0], "R2 half_clk level", int'(half_clk), int'(k[0]));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(posedge clk_ref);
    #1;
    check(half_clk == 1'b0, "R1 half_clk in reset", int'(half_clk), 0);
    check(cmp_strobe == 1'b0, "R1 strobe in reset", int'(cmp_strobe), 0);

    // Directed: short ratio, then long ratio.
    release_reset(1'b1);
    run_cycles(3 * 1024 + 5, 1, 0);
    // The next period was sampled as 1; switch to 0 for the ones after.
    run_cycles(1024, 0, 0);
    run_cycles(2 * 2048, 0, 0);

    // Random: flips inside periods must not move the strobe (R6).
    run_cycles(12000, -1, 20);

    // Reset in the middle of a period (R1).
    @(negedge clk_ref);
    rst_n = 1'b0;
    #1;
    check(half_clk == 1'b0, "R1 half_clk after mid reset", int'(half_clk), 0);
    check(cmp_strobe == 1'b0, "R1 strobe after mid reset", int'(cmp_strobe), 0);
    repeat (3) @(posedge clk_ref);
    #1;
    check(half_clk == 1'b0, "R1 half_clk held in reset", int'(half_clk), 0);
    release_reset(1'b0);
    run_cycles(2048 + 3, 1, 0);

    // Heavy toggling across the strobe cycle and mid-period.
    run_cycles(15000, -1, 300);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule